// File: doc/BRIEF.md
# Programmable Phase-Shifted Clock Divider

The block divides the system clock by sixteen and produces two square waves at that rate. The first, the divided clock, runs at a fixed 50% duty cycle. The second, the shifted clock, has the same frequency and duty cycle but lags the divided clock by a whole number of system-clock cycles. A 4-bit code sets that lag, so the sixteen codes cover a full turn of phase in 22.5° steps.

The lag code is sampled from the delay input only on a cycle where the load strobe is high. Between strobes the delay input is ignored, and the phase relationship stays fixed from one period to the next. A load never restarts the divide counter, so the divided clock keeps its own rhythm through any number of loads. Both outputs come straight from flip-flops clocked by the system clock. They are meant to be used as clock-like data signals, not as clocks for other logic.

Top module: `phsh_clkgen`

## Requirements
- R1: While rst_n is low, both outputs are low at once, whatever the clock is doing. The divide counter and the latched code are cleared to 0. After release, the first clock edge sets both outputs high, and they then follow code 0.
- R2: After the first period following reset, div_clk_o is high for exactly 8 system-clock cycles and then low for exactly 8, giving a period of 16 cycles. Loads do not alter this.
- R3: With latched code 0, sh_clk_o equals div_clk_o on every cycle.
- R4: With latched code d, sh_clk_o equals div_clk_o delayed by d system-clock cycles, which is d × 22.5°. Here d is the unsigned value of dly_i with bit 3 as the most significant bit, from 0 to 15. sh_clk_o keeps a 50% duty cycle for every code.
- R5: Changes on dly_i while load_i is low have no effect on sh_clk_o.
- R6: A code sampled with load_i high at a clock edge governs sh_clk_o from that same edge onward. When load_i is high on consecutive cycles, the last sampled code wins. The divide counter is not restarted.
- R7: Once a code is loaded, the lag stays constant over every following period until the next load.
- R8: A load on the cycle where the divided clock rises, or where it falls, leaves div_clk_o unchanged and moves sh_clk_o straight to the new phase. There is no skipped or extra transition on div_clk_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every flip-flop runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| load_i | input | 1 | Strobe that captures dly_i into the lag register |
| dly_i | input | 4 | Lag code in system-clock cycles (unsigned) |
| div_clk_o | output | 1 | Clock divided by 16, 50% duty |
| sh_clk_o | output | 1 | Divided clock lagged by the latched code |

## Verification
Two things can land on the same edge: a load, and a transition of the divided clock (the counter wrap or its midpoint). The bench waits on its own model's counter until it reaches the value just before each of these edges. It then pulses the load there and also drives back-to-back loads with different codes. A cycle-accurate reference model judges both outputs on every clock, so a load that nudges the counter or applies the old code for a cycle shows up as a miscompare. A reset asserted in the middle of a period is treated the same way.

// File: rtl/phsh_pkg.sv
package phsh_pkg;

  // Default counter width: the period is 2**PHSH_CW system-clock cycles.
  localparam int PHSH_CW = 4;

  // The two registered output levels, carried as one word.
  typedef struct packed {
    logic div;
    logic sh;
  } wave_t;

endpackage

// File: rtl/phsh_div_cnt.sv
// Free-running divide counter. It exposes both the registered value and the
// value it will take at the next edge.
module phsh_div_cnt #(
  parameter int CW = phsh_pkg::PHSH_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d
);

  logic cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_en ? cnt_q + CW'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/phsh_dly_reg.sv
// Lag-code register. The clock enable is the load strobe.
module phsh_dly_reg #(
  parameter int CW = phsh_pkg::PHSH_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] dly_i,
  output logic [CW-1:0] dly_d
);

  logic [CW-1:0] dly_q;

  always_comb begin
    dly_d = load_i ? dly_i : dly_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dly_q <= '0;
    else if (load_i) dly_q <= dly_d;
  end

endmodule

// File: rtl/phsh_wave.sv
// Output stage. Both levels are computed from next-state values, so the
// registered outputs line up with the counter and code held after each edge.
module phsh_wave #(
  parameter int CW = phsh_pkg::PHSH_CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  cnt_d,
  input  logic [CW-1:0]  dly_d,
  output phsh_pkg::wave_t wave_q
);

  logic [CW-1:0]   diff;
  phsh_pkg::wave_t wave_d;

  always_comb begin
    // The subtraction wraps modulo 2**CW. The lower half of the range is high.
    diff       = cnt_d - dly_d;
    wave_d.div = ~cnt_d[CW-1];
    wave_d.sh  = ~diff[CW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= '0;
    else        wave_q <= wave_d;
  end

endmodule

// File: rtl/phsh_clkgen.sv
module phsh_clkgen #(
  parameter int CW = phsh_pkg::PHSH_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] dly_i,
  output logic          div_clk_o,
  output logic          sh_clk_o
);

  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   cnt_d;
  logic [CW-1:0]   dly_d;
  phsh_pkg::wave_t wave_q;

  phsh_div_cnt #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d)
  );

  phsh_dly_reg #(.CW(CW)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .dly_i  (dly_i),
    .dly_d  (dly_d)
  );

  phsh_wave #(.CW(CW)) u_wave (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_d  (cnt_d),
    .dly_d  (dly_d),
    .wave_q (wave_q)
  );

  assign div_clk_o = wave_q.div;
  assign sh_clk_o  = wave_q.sh;

endmodule

// File: rtl/phsh_clkgen_chk.sv
module phsh_clkgen_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_i,
  input logic [CW-1:0] dly_i,
  input logic          div_clk_o,
  input logic          sh_clk_o
);

  localparam int PER  = 1 << CW;
  localparam int HALF = PER / 2;

  logic [PER-2:0] hist_q;
  logic [CW-1:0]  code_q;
  logic           prev_q;
  logic [CW:0]    run_q;
  logic [1:0]     tgl_q;
  logic [CW+1:0]  cyc_q;
  logic [PER-1:0] lag_vec;
  logic           warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      code_q <= '0;
      prev_q <= 1'b0;
      run_q  <= '0;
      tgl_q  <= '0;
      cyc_q  <= '0;
    end else begin
      hist_q <= {hist_q[PER-3:0], div_clk_o};
      if (load_i) code_q <= dly_i;
      prev_q <= div_clk_o;
      if (div_clk_o != prev_q) begin
        run_q <= (CW+1)'(1);
        if (tgl_q != 2'd2) tgl_q <= tgl_q + 2'd1;
      end else if (run_q != '1) begin
        run_q <= run_q + (CW+1)'(1);
      end
      if (cyc_q != '1) cyc_q <= cyc_q + (CW+2)'(1);
    end
  end

  assign lag_vec = {hist_q, div_clk_o};
  assign warm    = (cyc_q >= (CW+2)'(PER + 1));

  // R1: outputs held low while reset is applied
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_low_r1: assert (!div_clk_o && !sh_clk_o);
    end
  end

  p_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl_q == 2'd2 && div_clk_o != prev_q) |-> (run_q == (CW+1)'(HALF)));

  p_run_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl_q == 2'd2) |-> (run_q <= (CW+1)'(HALF)));

  p_code0_inphase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && dly_i == '0) |=> (sh_clk_o == div_clk_o));

  p_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (sh_clk_o == lag_vec[code_q]));

endmodule

bind phsh_clkgen phsh_clkgen_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_i    (load_i),
  .dly_i     (dly_i),
  .div_clk_o (div_clk_o),
  .sh_clk_o  (sh_clk_o)
);

// File: tb/test_phsh_clkgen.sv
module test_phsh_clkgen;

  localparam int P = 16;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [3:0] din = 4'd0;
  logic       div_w;
  logic       sh_w;

  int    n_vec = 0;
  int    n_bad = 0;
  int    m_cnt = 0;
  int    m_dly = 0;
  bit    m_rst = 1'b1;
  bit    done  = 1'b0;
  string req   = "R1";

  phsh_clkgen #(.CW(4)) i_phsh_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .dly_i     (din),
    .div_clk_o (div_w),
    .sh_clk_o  (sh_w)
  );

  always #10 clk = ~clk;

  // Reference model: counter and latched code, updated at each rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0;
      m_dly = 0;
      m_rst = 1'b1;
    end else begin
      m_cnt = (m_cnt + 1) % P;
      if (load) m_dly = int'(din);
      m_rst = 1'b0;
    end
  end

  // Compare on every falling edge, well away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      bit    e_div;
      bit    e_sh;
      string tag;
      e_div = m_rst ? 1'b0 : (m_cnt < H);
      e_sh  = m_rst ? 1'b0 : (((m_cnt - m_dly + P) % P) < H);
      n_vec++;
      tag = m_rst ? "R1" : "R2";
      if (div_w !== e_div) begin
        n_bad++;
        $display("FAIL %s: div_clk_o=%0b expected %0b (t=%0t)", tag, div_w, e_div, $time);
      end
      n_vec++;
      tag = m_rst ? "R1" : req;
      if (sh_w !== e_sh) begin
        n_bad++;
        $display("FAIL %s: sh_clk_o=%0b expected %0b (code %0d, t=%0t)", tag, sh_w, e_sh, m_dly, $time);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_load(input logic [3:0] code);
    din  = code;
    load = 1'b1;
    step(1);
    load = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    while (m_cnt != v) step(1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset state
    step(3);
    rst_n = 1'b1;
    // R2: division by 16 with 50% duty
    req = "R2";
    step(40);
    // R3: code 0 keeps both outputs in phase
    req = "R3";
    pulse_load(4'd0);
    step(40);
    // R4: code 4 gives a 90 degree lag
    req = "R4";
    pulse_load(4'd4);
    step(40);
    // R5: dly_i moves without a load and must be ignored
    req = "R5";
    for (int i = 0; i < 48; i++) begin
      din = 4'(i * 7);
      step(1);
    end
    // R4: sweep every code
    req = "R4";
    for (int c = 0; c < 16; c++) begin
      pulse_load(4'(c));
      step(34);
    end
    // R6: loads on back-to-back cycles; the last one wins, counter keeps running
    req = "R6";
    load = 1'b1;
    din = 4'd3; step(1);
    din = 4'd12; step(1);
    din = 4'd6; step(1);
    load = 1'b0;
    din = 4'd9;
    step(40);
    // R8: loads on the edges where the divided clock rises and falls
    req = "R8";
    wait_cnt(15);
    pulse_load(4'd7);
    step(20);
    wait_cnt(7);
    pulse_load(4'd13);
    step(20);
    wait_cnt(15);
    pulse_load(4'd0);
    step(20);
    // R7: a loaded phase holds over many periods while dly_i wanders
    req = "R7";
    pulse_load(4'd11);
    for (int i = 0; i < 100; i++) begin
      din = 4'(i);
      step(1);
    end
    // R1: reset in the middle of a period clears the counter and the code
    req = "R1";
    wait_cnt(5);
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(40);
    finish_run();
  end

endmodule